// File: doc/BRIEF.md
# Parallel ATA device task-file register block

This block is the device-side register file of a parallel ATA port. The host reaches it through two active-high block selects, a three-bit register address and single-cycle read and write strobes. The strobes are already synchronised to the device clock. The block keeps the parameter registers that describe a command: feature, sector count, the three address bytes and the drive/head byte. From those it presents a 28-bit logical block address, the addressing-mode flag and the device-select bit to the command engine.

Several addresses are asymmetric. The same offset names one register when read and another when written. The secondary status view reports the same value as the primary one without the side effect of a primary read. A command write does not execute anything here: it emits a one-cycle valid pulse carrying the 8-bit code. Data-port accesses are passed through as read and write pulses toward the sector buffer. The interrupt request is held pending until it is acknowledged. It reaches the host only when this device is the selected one and interrupts are enabled.

Top module: `ata_taskfile`

## Requirements
- R1: With `sel_cmd_blk`=1 and `sel_ctl_blk`=0, writes to address 1 (feature), 2 (sector count), 3 (sector number), 4 (cylinder low), 5 (cylinder high) and 6 (drive/head) store `wdata[7:0]`. Bits 15:8 are discarded. The stored value is visible on the outputs from the clock edge that takes the write. Without a write these outputs hold.
- R2: `lba` equals {drive/head[3:0], cylinder high, cylinder low, sector number}. `lba_mode` is drive/head bit 6 and `dev_sel` is drive/head bit 4.
- R3: Command-block reads return {8'h00, register} combinationally. Address 1 returns `dev_error`, and addresses 2 to 6 return the stored registers.
- R4: A command-block write to address 7 raises `cmd_valid` for exactly the following cycle, with `cmd_code` equal to the written `wdata[7:0]`. The same write clears the pending interrupt.
- R5: Address 0 of the command block is the 16-bit data port. A read returns `buf_rdata` on all 16 bits and raises `buf_rd` in the same cycle. A write raises `buf_wr` in the same cycle.
- R6: A command-block read of address 7 returns `dev_status` and clears the pending interrupt at that clock edge. A control-block read of address 6 returns the same `dev_status` and leaves the interrupt pending.
- R7: A control-block write to address 6 stores the device-control byte. Bit 1 drives `int_disable` and bit 2 drives `soft_reset`.
- R8: A control-block read of address 7 returns {2'b11, ~drive/head[3:0], ~dev_sel, dev_sel}. A control-block write to address 7 changes no register and produces no pulse.
- R9: While `dmack` is 1, every strobe is ignored. No register changes, no pulse is emitted, the interrupt is not acknowledged and `rdata` is zero.
- R10: `irq_set` marks the interrupt pending and wins over a clear in the same cycle. `intrq` is 1 only when the interrupt is pending, `dev_sel` equals `dev_id` and `int_disable` is 0.
- R11: When both selects are equal (both 0 or both 1) nothing is accessed and `rdata` is zero.
- R12: After reset every stored register is zero, no interrupt is pending and `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_cmd_blk | input | 1 | Command-block select, active high |
| sel_ctl_blk | input | 1 | Control-block select, active high |
| addr | input | 3 | Register offset |
| rd_stb | input | 1 | Host read strobe, one cycle |
| wr_stb | input | 1 | Host write strobe, one cycle |
| dmack | input | 1 | DMA acknowledge; blocks register decoding |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| buf_rdata | input | 16 | Data word from the sector buffer |
| buf_rd | output | 1 | Data-port read pulse |
| buf_wr | output | 1 | Data-port write pulse |
| dev_status | input | 8 | Status byte from the device core |
| dev_error | input | 8 | Error byte from the device core |
| irq_set | input | 1 | Core request to raise an interrupt |
| dev_id | input | 1 | This device's number (0 or 1) |
| cmd_valid | output | 1 | Command code valid, one cycle |
| cmd_code | output | 8 | Command code |
| features | output | 8 | Feature register |
| sector_count | output | 8 | Sector count register |
| lba | output | 28 | Assembled block address |
| lba_mode | output | 1 | Logical addressing selected |
| dev_sel | output | 1 | Device selected by drive/head |
| int_disable | output | 1 | Interrupt disable from device control |
| soft_reset | output | 1 | Software reset bit from device control |
| intrq | output | 1 | Interrupt request to the host |

## Verification
The bench builds the block with its defaults: 16-bit data and 8-bit registers, which form a 28-bit address. These widths reach every byte lane of `lba`, and writes with junk in the upper data byte show that the register path discards it. Each asymmetric offset is exercised in both directions. The interrupt is driven through acknowledge, secondary status, disable, device-mismatch and set-versus-clear collisions. DMA acknowledge and invalid select pairs are shown to leave all state untouched.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int ADDR_W = 3;

    // offsets whose meaning fixes the decoder behaviour
    localparam logic [ADDR_W-1:0] OFS_DATA    = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_ERRFEAT = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_SECNUM  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CYLLO   = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CYLHI   = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_DEVHEAD = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_STATCMD = 3'd7;
    localparam logic [ADDR_W-1:0] OFS_ALTCTL  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_DRVADDR = 3'd7;

    // bit positions that neighbours decode
    localparam int DH_LBA_BIT  = 6;
    localparam int DH_DEV_BIT  = 4;
    localparam int DH_HEAD_W   = 4;
    localparam int DC_NIEN_BIT = 1;
    localparam int DC_SRST_BIT = 2;

    typedef enum logic [3:0] {
        TF_NONE,
        TF_DATA,
        TF_ERRFEAT,
        TF_COUNT,
        TF_SECNUM,
        TF_CYLLO,
        TF_CYLHI,
        TF_DEVHEAD,
        TF_STATCMD,
        TF_ALTCTL,
        TF_DRVADDR
    } tf_sel_e;

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
(
    input  logic              sel_cmd_blk,
    input  logic              sel_ctl_blk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dmack,
    output tf_sel_e           sel
);

    always_comb begin
        sel = TF_NONE;
        if (!dmack) begin
            if (sel_cmd_blk && !sel_ctl_blk) begin
                case (addr)
                    OFS_DATA:    sel = TF_DATA;
                    OFS_ERRFEAT: sel = TF_ERRFEAT;
                    OFS_COUNT:   sel = TF_COUNT;
                    OFS_SECNUM:  sel = TF_SECNUM;
                    OFS_CYLLO:   sel = TF_CYLLO;
                    OFS_CYLHI:   sel = TF_CYLHI;
                    OFS_DEVHEAD: sel = TF_DEVHEAD;
                    default:     sel = TF_STATCMD;
                endcase
            end else if (!sel_cmd_blk && sel_ctl_blk) begin
                if (addr == OFS_ALTCTL)
                    sel = TF_ALTCTL;
                else if (addr == OFS_DRVADDR)
                    sel = TF_DRVADDR;
            end
        end
    end

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tf_sel_e          sel,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wbyte,
    input  logic             irq_set,
    output logic [REG_W-1:0] feat,
    output logic [REG_W-1:0] count,
    output logic [REG_W-1:0] secnum,
    output logic [REG_W-1:0] cyllo,
    output logic [REG_W-1:0] cylhi,
    output logic [REG_W-1:0] devhead,
    output logic [REG_W-1:0] devctl,
    output logic             irq_pend,
    output logic             cmd_valid,
    output logic [REG_W-1:0] cmd_code
);

    typedef struct packed {
        logic [REG_W-1:0] feat;
        logic [REG_W-1:0] count;
        logic [REG_W-1:0] secnum;
        logic [REG_W-1:0] cyllo;
        logic [REG_W-1:0] cylhi;
        logic [REG_W-1:0] devhead;
        logic [REG_W-1:0] devctl;
        logic             irq_pend;
        logic             cmd_valid;
        logic [REG_W-1:0] cmd_code;
    } tf_state_t;

    tf_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.cmd_valid = 1'b0;
        if (wr_stb) begin
            case (sel)
                TF_ERRFEAT: st_d.feat    = wbyte;
                TF_COUNT:   st_d.count   = wbyte;
                TF_SECNUM:  st_d.secnum  = wbyte;
                TF_CYLLO:   st_d.cyllo   = wbyte;
                TF_CYLHI:   st_d.cylhi   = wbyte;
                TF_DEVHEAD: st_d.devhead = wbyte;
                TF_ALTCTL:  st_d.devctl  = wbyte;
                TF_STATCMD: begin
                    st_d.cmd_valid = 1'b1;
                    st_d.cmd_code  = wbyte;
                    st_d.irq_pend  = 1'b0;
                end
                default: ;
            endcase
        end
        // primary status read acknowledges; the secondary view does not
        if (rd_stb && sel == TF_STATCMD)
            st_d.irq_pend = 1'b0;
        if (irq_set)
            st_d.irq_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign feat      = st_q.feat;
    assign count     = st_q.count;
    assign secnum    = st_q.secnum;
    assign cyllo     = st_q.cyllo;
    assign cylhi     = st_q.cylhi;
    assign devhead   = st_q.devhead;
    assign devctl    = st_q.devctl;
    assign irq_pend  = st_q.irq_pend;
    assign cmd_valid = st_q.cmd_valid;
    assign cmd_code  = st_q.cmd_code;

endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
    import ata_tf_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int DATA_W = 16
) (
    input  tf_sel_e           sel,
    input  logic              rd_stb,
    input  logic [REG_W-1:0]  dev_error,
    input  logic [REG_W-1:0]  dev_status,
    input  logic [REG_W-1:0]  count,
    input  logic [REG_W-1:0]  secnum,
    input  logic [REG_W-1:0]  cyllo,
    input  logic [REG_W-1:0]  cylhi,
    input  logic [REG_W-1:0]  devhead,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W  = DATA_W - REG_W;
    localparam int FILL_W = REG_W - DH_HEAD_W - 2;

    logic             dev_bit;
    logic [REG_W-1:0] drv_addr;
    logic [REG_W-1:0] byte_val;

    assign dev_bit  = devhead[DH_DEV_BIT];
    assign drv_addr = {{FILL_W{1'b1}}, ~devhead[DH_HEAD_W-1:0], ~dev_bit, dev_bit};

    always_comb begin
        case (sel)
            TF_ERRFEAT: byte_val = dev_error;
            TF_COUNT:   byte_val = count;
            TF_SECNUM:  byte_val = secnum;
            TF_CYLLO:   byte_val = cyllo;
            TF_CYLHI:   byte_val = cylhi;
            TF_DEVHEAD: byte_val = devhead;
            TF_STATCMD: byte_val = dev_status;
            TF_ALTCTL:  byte_val = dev_status;
            TF_DRVADDR: byte_val = drv_addr;
            default:    byte_val = '0;
        endcase
    end

    always_comb begin
        if (!rd_stb)
            rdata = '0;
        else if (sel == TF_DATA)
            rdata = buf_rdata;
        else
            rdata = {{PAD_W{1'b0}}, byte_val};
    end

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import ata_tf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8,
    localparam int LBA_W = DH_HEAD_W + 3 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_cmd_blk,
    input  logic              sel_ctl_blk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              dmack,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_rd,
    output logic              buf_wr,
    input  logic [REG_W-1:0]  dev_status,
    input  logic [REG_W-1:0]  dev_error,
    input  logic              irq_set,
    input  logic              dev_id,
    output logic              cmd_valid,
    output logic [REG_W-1:0]  cmd_code,
    output logic [REG_W-1:0]  features,
    output logic [REG_W-1:0]  sector_count,
    output logic [LBA_W-1:0]  lba,
    output logic              lba_mode,
    output logic              dev_sel,
    output logic              int_disable,
    output logic              soft_reset,
    output logic              intrq
);

    tf_sel_e          sel;
    logic [REG_W-1:0] secnum, cyllo, cylhi, devhead, devctl;
    logic             irq_pend;

    ata_tf_decode u_decode (
        .sel_cmd_blk (sel_cmd_blk),
        .sel_ctl_blk (sel_ctl_blk),
        .addr        (addr),
        .dmack       (dmack),
        .sel         (sel)
    );

    ata_tf_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wbyte     (wdata[REG_W-1:0]),
        .irq_set   (irq_set),
        .feat      (features),
        .count     (sector_count),
        .secnum    (secnum),
        .cyllo     (cyllo),
        .cylhi     (cylhi),
        .devhead   (devhead),
        .devctl    (devctl),
        .irq_pend  (irq_pend),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code)
    );

    ata_tf_rdmux #(.REG_W(REG_W), .DATA_W(DATA_W)) u_rdmux (
        .sel        (sel),
        .rd_stb     (rd_stb),
        .dev_error  (dev_error),
        .dev_status (dev_status),
        .count      (sector_count),
        .secnum     (secnum),
        .cyllo      (cyllo),
        .cylhi      (cylhi),
        .devhead    (devhead),
        .buf_rdata  (buf_rdata),
        .rdata      (rdata)
    );

    assign buf_rd      = rd_stb && (sel == TF_DATA);
    assign buf_wr      = wr_stb && (sel == TF_DATA);
    assign lba         = {devhead[DH_HEAD_W-1:0], cylhi, cyllo, secnum};
    assign lba_mode    = devhead[DH_LBA_BIT];
    assign dev_sel     = devhead[DH_DEV_BIT];
    assign int_disable = devctl[DC_NIEN_BIT];
    assign soft_reset  = devctl[DC_SRST_BIT];
    assign intrq       = irq_pend && (dev_sel == dev_id) && !int_disable;

endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_cmd_blk,
    input logic              sel_ctl_blk,
    input logic [2:0]        addr,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              dmack,
    input logic              irq_set,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              buf_rd,
    input logic              buf_wr,
    input logic              cmd_valid,
    input logic [REG_W-1:0]  cmd_code,
    input logic [REG_W-1:0]  sector_count,
    input logic              int_disable,
    input logic              intrq
);

    logic cmd_wr, alt_rd, stat_rd;
    assign cmd_wr  = wr_stb && sel_cmd_blk && !sel_ctl_blk && addr == 3'd7 && !dmack;
    assign alt_rd  = rd_stb && !sel_cmd_blk && sel_ctl_blk && addr == 3'd6 && !dmack;
    assign stat_rd = rd_stb && sel_cmd_blk && !sel_ctl_blk && addr == 3'd7 && !dmack;

    a_r4_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> cmd_valid && cmd_code == $past(wdata[REG_W-1:0]));

    a_r9_dmack_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        dmack |=> !cmd_valid);

    a_r9_dmack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dmack |-> rdata == '0 && !buf_rd && !buf_wr);

    a_r6_alt_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        alt_rd && !wr_stb && intrq |=> intrq);

    a_r6_status_acks: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !irq_set |=> !intrq);

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        int_disable |-> !intrq);

    a_r11_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cmd_blk == sel_ctl_blk) |-> rdata == '0);

    a_r1_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(sector_count));

endmodule

bind ata_taskfile ata_taskfile_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_cmd_blk  (sel_cmd_blk),
    .sel_ctl_blk  (sel_ctl_blk),
    .addr         (addr),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .dmack        (dmack),
    .irq_set      (irq_set),
    .wdata        (wdata),
    .rdata        (rdata),
    .buf_rd       (buf_rd),
    .buf_wr       (buf_wr),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .sector_count (sector_count),
    .int_disable  (int_disable),
    .intrq        (intrq)
);

// File: tb/ata_taskfile_test.sv
module ata_taskfile_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_cmd_blk = 1'b0, sel_ctl_blk = 1'b0;
    logic [2:0]  addr = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, dmack = 1'b0;
    logic [15:0] wdata = '0, buf_rdata = 16'hBEEF;
    logic [15:0] rdata;
    logic        buf_rd, buf_wr;
    logic [7:0]  dev_status = 8'h58, dev_error = 8'h04;
    logic        irq_set = 1'b0, dev_id = 1'b0;
    logic        cmd_valid;
    logic [7:0]  cmd_code, features, sector_count;
    logic [27:0] lba;
    logic        lba_mode, dev_sel, int_disable, soft_reset, intrq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile uut (
        .clk(clk), .rst_n(rst_n), .sel_cmd_blk(sel_cmd_blk), .sel_ctl_blk(sel_ctl_blk),
        .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .dmack(dmack), .wdata(wdata),
        .rdata(rdata), .buf_rdata(buf_rdata), .buf_rd(buf_rd), .buf_wr(buf_wr),
        .dev_status(dev_status), .dev_error(dev_error), .irq_set(irq_set), .dev_id(dev_id),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .features(features),
        .sector_count(sector_count), .lba(lba), .lba_mode(lba_mode), .dev_sel(dev_sel),
        .int_disable(int_disable), .soft_reset(soft_reset), .intrq(intrq)
    );

    typedef enum int {K_RDATA, K_LBA, K_FEAT, K_CNT, K_CMDV, K_CMDC, K_INTRQ,
                      K_BRD, K_BWR, K_MODE, K_DSEL, K_NIEN, K_SRST} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    function automatic logic [31:0] observe(kind_e k);
        case (k)
            K_RDATA: return {16'h0, rdata};
            K_LBA:   return {4'h0, lba};
            K_FEAT:  return {24'h0, features};
            K_CNT:   return {24'h0, sector_count};
            K_CMDV:  return {31'h0, cmd_valid};
            K_CMDC:  return {24'h0, cmd_code};
            K_INTRQ: return {31'h0, intrq};
            K_BRD:   return {31'h0, buf_rd};
            K_BWR:   return {31'h0, buf_wr};
            K_MODE:  return {31'h0, lba_mode};
            K_DSEL:  return {31'h0, dev_sel};
            K_NIEN:  return {31'h0, int_disable};
            default: return {31'h0, soft_reset};
        endcase
    endfunction

    // driver side: queue an expectation for this cycle's sample point
    task automatic expect_now(kind_e k, logic [31:0] e, string req);
        item_t it;
        it.kind = k;
        it.exp  = e;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    // monitor: samples a quarter period after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = observe(it.kind);
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: %s actual=%h expected=%h", it.req, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    task automatic host_wr(bit cmdblk, bit ctlblk, logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        sel_cmd_blk = cmdblk; sel_ctl_blk = ctlblk; addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; sel_cmd_blk = 1'b0; sel_ctl_blk = 1'b0;
    endtask

    // read; expectation sampled while the strobe is high
    task automatic host_rd(bit cmdblk, bit ctlblk, logic [2:0] a, logic [15:0] e, string req);
        @(negedge clk);
        sel_cmd_blk = cmdblk; sel_ctl_blk = ctlblk; addr = a; rd_stb = 1'b1;
        expect_now(K_RDATA, {16'h0, e}, req);
        @(negedge clk);
        rd_stb = 1'b0; sel_cmd_blk = 1'b0; sel_ctl_blk = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_set = 1'b1;
        @(negedge clk);
        irq_set = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        expect_now(K_LBA,   0, "R12");
        expect_now(K_FEAT,  0, "R12");
        expect_now(K_CNT,   0, "R12");
        expect_now(K_CMDV,  0, "R12");
        expect_now(K_INTRQ, 0, "R12");

        // R1 parameter writes with junk upper byte
        host_wr(1, 0, 3'd1, 16'hFF5A);
        expect_now(K_FEAT, 32'h5A, "R1");
        host_wr(1, 0, 3'd2, 16'hFF10);
        expect_now(K_CNT, 32'h10, "R1");
        host_wr(1, 0, 3'd3, 16'hFF78);
        host_wr(1, 0, 3'd4, 16'hFF56);
        host_wr(1, 0, 3'd5, 16'hFF34);
        host_wr(1, 0, 3'd6, 16'hFFE2);
        // R2 assembled address and flags
        expect_now(K_LBA,  32'h2345678, "R2");
        expect_now(K_MODE, 1, "R2");
        expect_now(K_DSEL, 0, "R2");

        // R3 byte reads
        host_rd(1, 0, 3'd1, 16'h0004, "R3");
        host_rd(1, 0, 3'd2, 16'h0010, "R3");
        host_rd(1, 0, 3'd3, 16'h0078, "R3");
        host_rd(1, 0, 3'd5, 16'h0034, "R3");
        host_rd(1, 0, 3'd6, 16'h00E2, "R3");

        // R4 command pulse
        host_wr(1, 0, 3'd7, 16'h00EC);
        expect_now(K_CMDV, 1, "R4");
        expect_now(K_CMDC, 32'hEC, "R4");
        @(negedge clk);
        expect_now(K_CMDV, 0, "R4");

        // R5 data port
        @(negedge clk);
        sel_cmd_blk = 1; addr = 3'd0; rd_stb = 1;
        expect_now(K_RDATA, 32'hBEEF, "R5");
        expect_now(K_BRD, 1, "R5");
        @(negedge clk);
        rd_stb = 0; wr_stb = 1; wdata = 16'h1234;
        expect_now(K_BWR, 1, "R5");
        expect_now(K_BRD, 0, "R5");
        @(negedge clk);
        wr_stb = 0; sel_cmd_blk = 0;

        // R10 raise, R6 secondary then primary status
        pulse_irq();
        expect_now(K_INTRQ, 1, "R10");
        host_rd(0, 1, 3'd6, 16'h0058, "R6");
        expect_now(K_INTRQ, 1, "R6");
        host_rd(1, 0, 3'd7, 16'h0058, "R6");
        expect_now(K_INTRQ, 0, "R6");

        // R7 device control
        host_wr(0, 1, 3'd6, 16'h0006);
        expect_now(K_NIEN, 1, "R7");
        expect_now(K_SRST, 1, "R7");
        pulse_irq();
        expect_now(K_INTRQ, 0, "R10");
        host_wr(0, 1, 3'd6, 16'h0000);
        expect_now(K_INTRQ, 1, "R10");
        expect_now(K_SRST, 0, "R7");
        // R10 other device selected
        host_wr(1, 0, 3'd6, 16'h00F2);
        expect_now(K_DSEL, 1, "R10");
        expect_now(K_INTRQ, 0, "R10");
        host_wr(1, 0, 3'd6, 16'h00E2);
        expect_now(K_INTRQ, 1, "R10");

        // R8 drive address read and ignored write
        host_rd(0, 1, 3'd7, 16'h00F6, "R8");
        host_wr(0, 1, 3'd7, 16'hFFFF);
        expect_now(K_CMDV, 0, "R8");
        expect_now(K_NIEN, 0, "R8");
        expect_now(K_SRST, 0, "R8");
        expect_now(K_LBA, 32'h2345678, "R8");

        // R9 DMA acknowledge blocks everything
        dmack = 1'b1;
        host_wr(1, 0, 3'd2, 16'h0099);
        expect_now(K_CNT, 32'h10, "R9");
        host_wr(1, 0, 3'd7, 16'h0020);
        expect_now(K_CMDV, 0, "R9");
        host_rd(1, 0, 3'd7, 16'h0000, "R9");
        @(negedge clk);
        sel_cmd_blk = 1; addr = 3'd0; rd_stb = 1;
        expect_now(K_BRD, 0, "R9");
        expect_now(K_RDATA, 0, "R9");
        @(negedge clk);
        rd_stb = 0; sel_cmd_blk = 0; dmack = 1'b0;
        expect_now(K_INTRQ, 1, "R9");

        // R11 invalid select pairs
        host_wr(1, 1, 3'd1, 16'h0011);
        expect_now(K_FEAT, 32'h5A, "R11");
        host_rd(0, 0, 3'd2, 16'h0000, "R11");
        host_rd(1, 1, 3'd2, 16'h0000, "R11");

        // R10 set wins over a status-read clear in the same cycle
        @(negedge clk);
        sel_cmd_blk = 1; addr = 3'd7; rd_stb = 1; irq_set = 1;
        @(negedge clk);
        rd_stb = 0; irq_set = 0; sel_cmd_blk = 0;
        expect_now(K_INTRQ, 1, "R10");

        // R4 command write clears pending interrupt
        host_wr(1, 0, 3'd7, 16'h0020);
        expect_now(K_INTRQ, 0, "R4");
        expect_now(K_CMDC, 32'h20, "R4");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule